// File: doc/BRIEF.md
# Three-Configuration RC Ratio Sequencer

This block sits above a discharge-count measurement controller and turns three measurements into one figure for a small interconnect time constant. A pulse on the start input makes it run the inner controller three times. Before each run it sets two network-select lines. One line puts a series resistor into the discharge path. The other connects an extra capacitor to the storage node. Each of the three amplified time constants therefore yields its own discharge count. The three counts are latched and presented at the outputs.

Once the third count is in, the block forms the product of the first two counts and divides it by the third. A multiplier does the product and a restoring divider does the division, taking one quotient bit per clock. The quotient is an unsigned fixed-point value with 10 integer and 8 fraction bits, in units of the clock period divided by ln 2. In the product-over-quotient form, the quantization error of each run mostly cancels against the others. The result is therefore far finer than a single direct count of the small time constant. A division by zero, an inner run that reports an error, or a quotient too large for the integer field all raise an error flag and give a zero result.

States: IDLE (waiting for start), ARM (selects settle for the current configuration), KICK (one-cycle start to the inner controller), WAIT (waiting for the inner run to finish), DIVGO (launches the divider), DIVWAIT (divider running), DONE (one-cycle completion). Transitions: IDLE→ARM on start. ARM→KICK and KICK→WAIT always. WAIT→ARM on run completion for the first two configurations. WAIT→DIVGO on the third completion with no error seen. WAIT→DONE on the third completion when an error was seen. DIVGO→DIVWAIT always. DIVWAIT→DONE when the divider finishes. DONE→IDLE always.

Top module: `rc_triple_seq`

## Requirements
- R1: After reset: busy_o, done_o, run_start_o and err_o are 0, ratio_o and the three count outputs are 0, sel_res_o is 1 and sel_cap_o is 0.
- R2: A start pulse in idle raises busy_o on the next cycle. The block then runs three inner measurements in fixed order, with the selects {sel_res_o, sel_cap_o} set as follows: run 1 is 2'b10 (resistor inserted, no extra capacitor), run 2 is 2'b01 (resistor bypassed, capacitor connected), run 3 is 2'b11 (both).
- R3: sel_res_o and sel_cap_o do not change between a run_start_o pulse and the run_done_i that answers it.
- R4: run_start_o is a one-cycle pulse. Exactly three are issued per measurement, and none is issued while a run is outstanding.
- R5: The value on run_count_i at the run_done_i of run k (k = 1, 2, 3) appears on cntk_o.
- R6: When N3 is nonzero, N1·N2 < N3·1024 and no run reports an error, ratio_o equals floor(N1·N2·256 / N3), with bits [17:8] the integer part and bits [7:0] the fraction. err_o is 0 in this case.
- R7: When N3 is zero, err_o is 1 and ratio_o is 0.
- R8: When run_err_i is high at any run's completion, all three runs are still performed, the division is skipped, err_o is 1 and ratio_o is 0.
- R9: When N1·N2 ≥ N3·1024 (quotient beyond the integer field), err_o is 1 and ratio_o is 0.
- R10: A start pulse while busy_o is high has no effect: it causes no extra inner run and no new measurement after done.
- R11: done_o is high for exactly one cycle, and busy_o is still high in that cycle. In the next cycle both are low. ratio_o and err_o keep their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a three-run measurement |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sel_res_o | output | 1 | Insert series resistor |
| sel_cap_o | output | 1 | Connect extra capacitor |
| run_start_o | output | 1 | Start pulse to inner controller |
| run_done_i | input | 1 | Inner run finished |
| run_err_i | input | 1 | Inner run failed (valid with run_done_i) |
| run_count_i | input | 10 | Discharge count of the finished run |
| cnt1_o | output | 10 | Count of configuration 1 |
| cnt2_o | output | 10 | Count of configuration 2 |
| cnt3_o | output | 10 | Count of configuration 3 |
| ratio_o | output | 18 | N1·N2/N3, 10.8 unsigned fixed point |
| err_o | output | 1 | Result invalid |

## Verification
The bench's stand-in for the inner controller returns a count chosen by the select lines it sees. A design that swapped the run order or mis-decoded a select would therefore latch the wrong counts and compute the wrong ratio. The value sets cover several boundaries. A quotient of exactly 1023.0 must pass, and a quotient just over 1024 must flag. Zero counts are included, as is a zero divisor, which a design lacking the guard would turn into an all-ones quotient. An error in the middle run is included too, and a design that aborted early or still divided would show a wrong run count or a nonzero result. Start pulses given in the middle of a run check that a design cannot retrigger, which would show up as extra inner runs or a second done.

// File: rtl/rc_triple_pkg.sv
package rc_triple_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_KICK,
        ST_WAIT,
        ST_DIVGO,
        ST_DIVWAIT,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] CFG_SERIES = 2'd0;
    localparam logic [1:0] CFG_SHUNT  = 2'd1;
    localparam logic [1:0] CFG_BOTH   = 2'd2;

endpackage

// File: rtl/rc_ratio_div.sv
module rc_ratio_div #(
    parameter int CW = 10,
    parameter int IW = 10,
    parameter int FW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [CW-1:0]     a_i,
    input  logic [CW-1:0]     b_i,
    input  logic [CW-1:0]     d_i,
    output logic              fin_o,
    output logic              ovf_o,
    output logic [IW+FW-1:0]  quo_o
);
    localparam int QW   = IW + FW;
    localparam int PW   = 2 * CW;
    localparam int NW   = PW + FW;
    localparam int CNTW = $clog2(QW + 1);

    logic [PW-1:0]   prod;
    logic [PW-1:0]   prod_hi;
    logic            bad;
    logic [CW-1:0]   rem_q;
    logic [QW-1:0]   sh_q;
    logic [QW-1:0]   quo_q;
    logic [CNTW-1:0] cnt_q;
    logic            active_q;
    logic            fin_q;
    logic            ovf_q;
    logic [CW:0]     trial;
    logic            take;

    // product of the first two counts, and its part above the integer field
    assign prod    = PW'(a_i) * PW'(b_i);
    assign prod_hi = prod >> IW;
    assign bad     = (d_i == '0) || (prod_hi >= PW'(d_i));

    // one restoring step per cycle
    assign trial = {rem_q, sh_q[QW-1]};
    assign take  = (trial >= {1'b0, d_i});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            sh_q     <= '0;
            quo_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            fin_q    <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go_i) begin
                quo_q <= '0;
                if (bad) begin
                    ovf_q <= 1'b1;
                    fin_q <= 1'b1;
                end else begin
                    ovf_q    <= 1'b0;
                    rem_q    <= CW'(prod_hi);
                    sh_q     <= {prod[IW-1:0], {FW{1'b0}}};
                    cnt_q    <= CNTW'(QW);
                    active_q <= 1'b1;
                end
            end else if (active_q) begin
                rem_q <= take ? CW'(trial - {1'b0, d_i}) : CW'(trial);
                sh_q  <= sh_q << 1;
                quo_q <= {quo_q[QW-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNTW'(1)) begin
                    active_q <= 1'b0;
                    fin_q    <= 1'b1;
                end
            end
        end
    end

    assign fin_o = fin_q;
    assign ovf_o = ovf_q;
    assign quo_o = quo_q;

    // invariant checks on the finished quotient
    logic [NW-1:0] num_chk;
    logic [NW-1:0] back_chk;
    assign num_chk  = {prod, {FW{1'b0}}};
    assign back_chk = NW'(quo_q) * NW'(d_i);

    a_r6_quotient_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q && !ovf_q) |-> ((back_chk <= num_chk) && ((num_chk - back_chk) < NW'(d_i))));

    a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q && d_i == '0) |-> ovf_q);

endmodule

// File: rtl/rc_seq_ctrl.sv
module rc_seq_ctrl
    import rc_triple_pkg::*;
#(
    parameter int CW = 10,
    parameter int QW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          sel_res_o,
    output logic          sel_cap_o,
    output logic          run_start_o,
    input  logic          run_done_i,
    input  logic          run_err_i,
    input  logic [CW-1:0] run_count_i,
    output logic [CW-1:0] n1_o,
    output logic [CW-1:0] n2_o,
    output logic [CW-1:0] n3_o,
    output logic          div_go_o,
    input  logic          div_fin_i,
    input  logic          div_ovf_i,
    input  logic [QW-1:0] div_quo_i,
    output logic [QW-1:0] ratio_o,
    output logic          err_o
);
    seq_state_t    state_q, state_d;
    logic [1:0]    cfg_q;
    logic          err_acc_q;
    logic          err_now;
    logic [CW-1:0] n1_q, n2_q, n3_q;
    logic [QW-1:0] ratio_q;
    logic          err_q;

    assign err_now = err_acc_q | run_err_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ARM;
            ST_ARM:     state_d = ST_KICK;
            ST_KICK:    state_d = ST_WAIT;
            ST_WAIT:    if (run_done_i) begin
                            if (cfg_q != CFG_BOTH) state_d = ST_ARM;
                            else if (err_now)      state_d = ST_DONE;
                            else                   state_d = ST_DIVGO;
                        end
            ST_DIVGO:   state_d = ST_DIVWAIT;
            ST_DIVWAIT: if (div_fin_i) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        run_start_o = (state_q == ST_KICK);
        div_go_o    = (state_q == ST_DIVGO);
        sel_res_o   = (cfg_q != CFG_SHUNT);
        sel_cap_o   = (cfg_q != CFG_SERIES);
    end

    // configuration index, latched counts and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= CFG_SERIES;
            err_acc_q <= 1'b0;
            n1_q      <= '0;
            n2_q      <= '0;
            n3_q      <= '0;
            ratio_q   <= '0;
            err_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                cfg_q     <= CFG_SERIES;
                err_acc_q <= 1'b0;
            end
            if (state_q == ST_WAIT && run_done_i) begin
                err_acc_q <= err_now;
                unique case (cfg_q)
                    CFG_SERIES: n1_q <= run_count_i;
                    CFG_SHUNT:  n2_q <= run_count_i;
                    default:    n3_q <= run_count_i;
                endcase
                if (cfg_q != CFG_BOTH) begin
                    cfg_q <= cfg_q + 2'd1;
                end else if (err_now) begin
                    ratio_q <= '0;
                    err_q   <= 1'b1;
                end
            end
            if (state_q == ST_DIVWAIT && div_fin_i) begin
                ratio_q <= div_ovf_i ? '0 : div_quo_i;
                err_q   <= div_ovf_i;
            end
        end
    end

    assign n1_o    = n1_q;
    assign n2_o    = n2_q;
    assign n3_o    = n3_q;
    assign ratio_o = ratio_q;
    assign err_o   = err_q;

    a_r3_select_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_KICK) || (state_q == ST_WAIT && !run_done_i))
            |=> $stable({sel_res_o, sel_cap_o}));

    a_r4_kick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        run_start_o |=> !run_start_o);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/rc_triple_seq.sv
module rc_triple_seq #(
    parameter int CW = 10,
    parameter int IW = 10,
    parameter int FW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             sel_res_o,
    output logic             sel_cap_o,
    output logic             run_start_o,
    input  logic             run_done_i,
    input  logic             run_err_i,
    input  logic [CW-1:0]    run_count_i,
    output logic [CW-1:0]    cnt1_o,
    output logic [CW-1:0]    cnt2_o,
    output logic [CW-1:0]    cnt3_o,
    output logic [IW+FW-1:0] ratio_o,
    output logic             err_o
);
    localparam int QW = IW + FW;

    logic          div_go;
    logic          div_fin;
    logic          div_ovf;
    logic [QW-1:0] div_quo;

    rc_seq_ctrl #(.CW(CW), .QW(QW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .sel_res_o   (sel_res_o),
        .sel_cap_o   (sel_cap_o),
        .run_start_o (run_start_o),
        .run_done_i  (run_done_i),
        .run_err_i   (run_err_i),
        .run_count_i (run_count_i),
        .n1_o        (cnt1_o),
        .n2_o        (cnt2_o),
        .n3_o        (cnt3_o),
        .div_go_o    (div_go),
        .div_fin_i   (div_fin),
        .div_ovf_i   (div_ovf),
        .div_quo_i   (div_quo),
        .ratio_o     (ratio_o),
        .err_o       (err_o)
    );

    rc_ratio_div #(.CW(CW), .IW(IW), .FW(FW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (div_go),
        .a_i   (cnt1_o),
        .b_i   (cnt2_o),
        .d_i   (cnt3_o),
        .fin_o (div_fin),
        .ovf_o (div_ovf),
        .quo_o (div_quo)
    );

endmodule

// File: tb/rc_triple_seq_test.sv
`timescale 1ns/1ps
module rc_triple_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        run_done_i = 1'b0;
    logic        run_err_i = 1'b0;
    logic [9:0]  run_count_i = '0;
    logic        busy_o, done_o, sel_res_o, sel_cap_o, run_start_o, err_o;
    logic [9:0]  cnt1_o, cnt2_o, cnt3_o;
    logic [17:0] ratio_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rc_triple_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .sel_res_o(sel_res_o), .sel_cap_o(sel_cap_o), .run_start_o(run_start_o),
        .run_done_i(run_done_i), .run_err_i(run_err_i), .run_count_i(run_count_i),
        .cnt1_o(cnt1_o), .cnt2_o(cnt2_o), .cnt3_o(cnt3_o), .ratio_o(ratio_o), .err_o(err_o)
    );

    // vector: [31:30] run that fails (0 none), [29:20] N1, [19:10] N2, [9:0] N3
    localparam int NV = 11;
    localparam logic [31:0] VEC [NV] = '{
        {2'd0, 10'd26,   10'd32,   10'd270},
        {2'd0, 10'd1,    10'd1,    10'd1},
        {2'd0, 10'd1023, 10'd1023, 10'd1023},
        {2'd0, 10'd1023, 10'd1023, 10'd1022},
        {2'd0, 10'd0,    10'd5,    10'd7},
        {2'd0, 10'd5,    10'd7,    10'd0},
        {2'd0, 10'd100,  10'd3,    10'd300},
        {2'd2, 10'd30,   10'd40,   10'd500},
        {2'd0, 10'd3,    10'd1,    10'd7},
        {2'd0, 10'd32,   10'd32,   10'd1},
        {2'd0, 10'd1023, 10'd1,    10'd1}
    };

    // inner-controller stand-in and protocol monitor
    int         kicks = 0, viol3 = 0, viol4 = 0, lat = 0, err_cfg = 0, cur_idx = 0;
    logic       mbusy = 1'b0;
    logic [5:0] seq = '0;
    logic [1:0] prev_sel = 2'b10;
    logic [9:0] m_n1 = '0, m_n2 = '0, m_n3 = '0;

    function automatic int sel_idx(input logic [1:0] s);
        case (s)
            2'b10:   return 1;
            2'b01:   return 2;
            2'b11:   return 3;
            default: return 0;
        endcase
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            run_done_i = 1'b0;
            run_err_i  = 1'b0;
            if ({sel_res_o, sel_cap_o} != prev_sel && mbusy) viol3++;
            prev_sel = {sel_res_o, sel_cap_o};
            if (run_start_o) begin
                kicks++;
                if (mbusy) viol4++;
                else begin
                    mbusy   = 1'b1;
                    lat     = 3;
                    cur_idx = sel_idx({sel_res_o, sel_cap_o});
                    seq     = {seq[3:0], 2'(cur_idx)};
                end
            end else if (mbusy) begin
                if (lat == 0) begin
                    run_done_i  = 1'b1;
                    run_err_i   = (cur_idx == err_cfg);
                    run_count_i = (cur_idx == 1) ? m_n1 : (cur_idx == 2) ? m_n2 :
                                  (cur_idx == 3) ? m_n3 : 10'h3FF;
                    mbusy = 1'b0;
                end else lat--;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        ok = done_o;
    endtask

    task automatic measure(input logic [31:0] v, input bit poke_busy);
        longint p, exp_r;
        bit     exp_e, ok;
        logic [17:0] held;
        err_cfg = int'(v[31:30]);
        m_n1 = v[29:20]; m_n2 = v[19:10]; m_n3 = v[9:0];
        kicks = 0; seq = '0; viol3 = 0; viol4 = 0;
        p = longint'(m_n1) * longint'(m_n2);
        exp_e = (err_cfg != 0) || (m_n3 == 0) || (p >= longint'(m_n3) * 1024);
        exp_r = exp_e ? 0 : (p * 256) / longint'(m_n3);
        pulse_start();
        chk("R2 busy after start", busy_o, 1);
        if (poke_busy) begin
            repeat (6) @(negedge clk);
            start_i = 1'b1;
            repeat (4) @(negedge clk);
            start_i = 1'b0;
        end
        wait_done(ok);
        chk("R11 done reached", ok, 1);
        chk("R11 busy during done", busy_o, 1);
        chk("R2 run order", seq, 6'b01_10_11);
        chk("R4 three kicks", kicks, 3);
        chk("R4 no kick while outstanding", viol4, 0);
        chk("R3 selects held during run", viol3, 0);
        chk("R5 cnt1", cnt1_o, m_n1);
        chk("R5 cnt2", cnt2_o, m_n2);
        chk("R5 cnt3", cnt3_o, m_n3);
        if (err_cfg != 0)        chk("R8 error flag", err_o, 1);
        else if (m_n3 == 0)      chk("R7 error flag", err_o, 1);
        else if (exp_e)          chk("R9 error flag", err_o, 1);
        else                     chk("R6 error flag", err_o, 0);
        chk(exp_e ? "R7 R8 R9 zero result" : "R6 ratio", ratio_o, exp_r);
        held = ratio_o;
        @(negedge clk);
        chk("R11 done low after pulse", done_o, 0);
        chk("R11 busy low after done", busy_o, 0);
        repeat (5) @(negedge clk);
        chk("R10 R11 no restart, result held", {busy_o, ratio_o}, {1'b0, held});
        if (poke_busy) chk("R10 kicks with start while busy", kicks, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 run_start", run_start_o, 0);
        chk("R1 ratio and err", {ratio_o, err_o}, 0);
        chk("R1 counts", {cnt1_o, cnt2_o, cnt3_o}, 0);
        chk("R1 selects", {sel_res_o, sel_cap_o}, 2'b10);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", {busy_o, done_o}, 0);

        for (int i = 0; i < NV; i++) measure(VEC[i], 1'b0);

        // R10 start held and pulsed while busy
        measure({2'd0, 10'd26, 10'd32, 10'd270}, 1'b1);
        measure({2'd1, 10'd9, 10'd9, 10'd9}, 1'b1);

        // reset in the middle of a measurement
        m_n1 = 10'd4; m_n2 = 10'd4; m_n3 = 10'd4; err_cfg = 0;
        pulse_start();
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-run busy", busy_o, 0);
        chk("R1 reset mid-run ratio", ratio_o, 0);
        chk("R1 reset mid-run selects", {sel_res_o, sel_cap_o}, 2'b10);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        measure({2'd0, 10'd4, 10'd4, 10'd4}, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule